// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects sixty-four peripheral interrupt lines into two banks of thirty-two. The low bank holds sources 0 to 31 and the extended bank holds sources 32 to 63. Each line sets a sticky pending flag. Software acknowledges pending flags by writing ones to a clear register. A per-source enable mask decides which pending flags are reported. The processor sees one interrupt request line, which is high while any enabled source is pending.

Software reaches the block over a simple 32-bit register bus with byte offsets. Reads are combinational from the offset, and writes take effect at the clock edge. A helper output gives the number of the lowest active source and a valid bit. A handler can therefore pick its next source without scanning the status words.

Top module: `irqc_top`

## Requirements
- R1: Source n belongs to bank n/32, bit n%32. The registers sit at these byte offsets, with the extended bank always 0x04 above the low bank: clear 0x00/0x04, enable 0x10/0x14, status 0x18/0x1C. Address bits [1:0] are ignored.
- R2: A pending flag sets on every clock cycle where its source input is high. It stays set until it is cleared.
- R3: Writing to a clear register clears the pending flag of each bit written as 1. Bits written as 0 leave their flags unchanged.
- R4: If a source is high in the same cycle as a clear write to its bit, the flag stays set.
- R5: Both enable registers reset to zero. An enable register reads back the last value written to it.
- R6: A status register reads as pending AND enable for its bank. Writes to a status register change nothing.
- R7: `irq_req` is high one cycle after any status bit in either bank is 1, and low one cycle after all status bits are 0.
- R8: When any status bit is set, `act_valid` is 1 and `act_idx` is the lowest set source number, so the low bank wins over the extended bank. When no status bit is set, `act_valid` is 0 and `act_idx` is 0.
- R9: A clear register reads back that bank's raw pending flags, with no masking applied.
- R10: Reads from an offset not listed in R1 return zero. Writes to such an offset change nothing.
- R11: Reset clears every pending flag and drives `irq_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 64 | Level interrupt inputs, one per source |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq_req | output | 1 | Registered request to the processor |
| act_idx | output | 6 | Lowest active source number |
| act_valid | output | 1 | Some enabled source is pending |

## Verification
The bench builds the block with its default parameters: two banks of thirty-two sources and an 8-bit offset. This puts the bank boundary at source 31/32 within reach, so the bench can test whether the helper output prefers the low bank. It also lets the bench write to the unused offsets between the register groups. A behavioural model holds 64-bit flag and enable vectors. The bench compares the read data, the request line and the helper outputs against that model on every cycle. Directed cases cover clears that land in the same cycle as an assertion, and writes to status or unmapped offsets. Random traffic follows the directed cases.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CLR  = 2'd1,
        RK_EN   = 2'd2,
        RK_STAT = 2'd3
    } reg_kind_e;

    // Word index of the first register of each group.
    localparam int CLR_WORD  = 0;
    localparam int EN_WORD   = 4;
    localparam int STAT_WORD = 6;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  bank;
    } reg_sel_t;

    function automatic reg_sel_t decode_word(input int unsigned word, input int unsigned nbanks);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.bank = '0;
        if (word >= CLR_WORD && word < CLR_WORD + nbanks) begin
            s.kind = RK_CLR;
            s.bank = 4'(word - CLR_WORD);
        end else if (word >= EN_WORD && word < EN_WORD + nbanks) begin
            s.kind = RK_EN;
            s.bank = 4'(word - EN_WORD);
        end else if (word >= STAT_WORD && word < STAT_WORD + nbanks) begin
            s.kind = RK_STAT;
            s.bank = 4'(word - STAT_WORD);
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        sel = decode_word(int'(unsigned'(word)), NUM_BANKS);
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] src,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] flag_q,
    output logic [BANK_W-1:0] en_q,
    output logic [BANK_W-1:0] status
);
    logic [BANK_W-1:0] clr_mask;

    assign clr_mask = clr_we ? wdata : '0;
    assign status   = flag_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | src;
            if (en_we) begin
                en_q <= wdata;
            end
        end
    end

    // R2 / R4: a high input always leaves its flag set, clear or not
    p_src_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (|src) |=> ((flag_q & $past(src)) == $past(src)));

    // R3: a flag only falls where a clear bit was written
    p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (rst)
        ((($past(flag_q) & ~$past(clr_mask)) & ~flag_q) == '0));

    // R5: enables leave reset at zero
    p_enable_reset_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '0));
endmodule

// File: rtl/irqc_ffs.sv
module irqc_ffs #(
    parameter int N = 64
) (
    input  logic [N-1:0]         vec,
    output logic [$clog2(N)-1:0] idx,
    output logic                 valid
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

    // R8: the reported index points at an active bit
    always_comb begin
        if (valid) begin
            p_idx_hits_r8: assert (vec[idx]);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_BANKS*BANK_W-1:0]       irq_src,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_wr,
    input  logic [BANK_W-1:0]                 bus_wdata,
    output logic [BANK_W-1:0]                 bus_rdata,
    output logic                              irq_req,
    output logic [$clog2(NUM_BANKS*BANK_W)-1:0] act_idx,
    output logic                              act_valid
);
    localparam int NUM_SRC = NUM_BANKS * BANK_W;

    reg_sel_t            sel;
    logic [NUM_SRC-1:0]  flag_all;
    logic [NUM_SRC-1:0]  en_all;
    logic [NUM_SRC-1:0]  stat_all;

    irqc_regdec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (sel.bank == 4'(b));

        irqc_bank #(
            .BANK_W (BANK_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .src    (irq_src[b*BANK_W +: BANK_W]),
            .clr_we (bus_wr && hit && sel.kind == RK_CLR),
            .en_we  (bus_wr && hit && sel.kind == RK_EN),
            .wdata  (bus_wdata),
            .flag_q (flag_all[b*BANK_W +: BANK_W]),
            .en_q   (en_all[b*BANK_W +: BANK_W]),
            .status (stat_all[b*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.bank == 4'(b)) begin
                unique case (sel.kind)
                    RK_CLR:  bus_rdata = flag_all[b*BANK_W +: BANK_W];
                    RK_EN:   bus_rdata = en_all[b*BANK_W +: BANK_W];
                    RK_STAT: bus_rdata = stat_all[b*BANK_W +: BANK_W];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req <= 1'b0;
        end else begin
            irq_req <= |stat_all;
        end
    end

    irqc_ffs #(
        .N (NUM_SRC)
    ) u_ffs (
        .vec   (stat_all),
        .idx   (act_idx),
        .valid (act_valid)
    );

    // R7: request follows the status OR with one cycle of latency
    p_req_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (|stat_all) |=> irq_req);
    p_req_drops_r7: assert property (@(posedge clk) disable iff (rst)
        !(|stat_all) |=> !irq_req);

    // R10: an unmapped offset reads as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (sel.kind == RK_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] irq_src;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [5:0]  act_idx;
    logic        act_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irqc_top uut (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .act_idx   (act_idx),
        .act_valid (act_valid)
    );

    // Behavioural reference
    logic [63:0] m_flag;
    logic [63:0] m_en;
    logic        m_irq;

    always @(posedge clk) begin
        logic [63:0] clr;
        clr = '0;
        if (rst) begin
            m_flag <= '0;
            m_en   <= '0;
            m_irq  <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == 8'h00) clr[31:0]  = bus_wdata;
            if (bus_wr && bus_addr == 8'h04) clr[63:32] = bus_wdata;
            m_flag <= (m_flag & ~clr) | irq_src;
            if (bus_wr && bus_addr == 8'h10) m_en[31:0]  <= bus_wdata;
            if (bus_wr && bus_addr == 8'h14) m_en[63:32] <= bus_wdata;
            m_irq <= |(m_flag & m_en);
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [63:0] st;
        st = m_flag & m_en;
        case (a)
            8'h00:   return m_flag[31:0];
            8'h04:   return m_flag[63:32];
            8'h10:   return m_en[31:0];
            8'h14:   return m_en[63:32];
            8'h18:   return st[31:0];
            8'h1C:   return st[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R9/R2/R3/R4";
            8'h10, 8'h14: return "R5";
            8'h18, 8'h1C: return "R6";
            default:      return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done && rst !== 1'bx) begin
            logic [63:0] st;
            logic [6:0]  lo;
            st = m_flag & m_en;
            lo = 7'd64;
            for (int i = 63; i >= 0; i--) if (st[i]) lo = 7'(i);
            check(rd_tag(bus_addr), 64'(bus_rdata), 64'(exp_rd(bus_addr)));
            check("R7", 64'(irq_req), 64'(m_irq));
            check("R8 valid", 64'(act_valid), 64'(lo != 7'd64));
            check("R8 index", 64'(act_idx), (lo == 7'd64) ? 64'd0 : 64'(lo));
        end
    end

    task automatic step(input logic [63:0] s, input logic w, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        irq_src   = s;
        bus_wr    = w;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_src = '0; bus_wr = 0; bus_addr = 8'h00; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11 / R5: reset state
        check("R11 irq_req", 64'(irq_req), 64'd0);
        check("R11 flags", 64'(bus_rdata), 64'd0);
        rst = 1'b0;
        step('0, 0, 8'h10, 0);
        check("R5 enable reset", 64'(bus_rdata), 64'd0);
        // R1: source 3 lands in the low bank, source 40 in the extended bank bit 8
        step(64'h0000_0100_0000_0008, 0, 8'h00, 0);
        step('0, 0, 8'h00, 0);
        step('0, 0, 8'h04, 0);
        #3 check("R1 extended bank bit", 64'(bus_rdata), 64'h100);
        // R6: masked, nothing in status
        step('0, 0, 8'h18, 0);
        // enable source 40 only; extended reported
        step('0, 1, 8'h14, 32'h100);
        step('0, 0, 8'h1C, 0);
        #3 check("R6 status ext", 64'(bus_rdata), 64'h100);
        step('0, 0, 8'h1C, 0);
        #3 check("R8 ext index", 64'(act_idx), 64'd40);
        // enable source 3; low bank wins
        step('0, 1, 8'h10, 32'h8);
        step('0, 0, 8'h18, 0);
        #3 check("R8 low bank first", 64'(act_idx), 64'd3);
        // R6: write to status is ignored
        step('0, 1, 8'h18, 32'hFFFF_FFFF);
        step('0, 0, 8'h10, 0);
        #3 check("R6 status write ignored", 64'(bus_rdata), 64'h8);
        // R10: unmapped write ignored
        step('0, 1, 8'h08, 32'hFFFF_FFFF);
        step('0, 1, 8'h3C, 32'hFFFF_FFFF);
        step('0, 0, 8'h00, 0);
        #3 check("R10 unmapped write", 64'(bus_rdata), 64'h8);
        // R3: zero bits keep flags, one bits clear
        step('0, 1, 8'h00, 32'h0);
        step('0, 1, 8'h00, 32'h8);
        step('0, 0, 8'h00, 0);
        #3 check("R3 cleared", 64'(bus_rdata), 64'h0);
        // R4: clear while the source is held high
        step(64'h8, 1, 8'h00, 32'h8);
        step(64'h8, 1, 8'h00, 32'h8);
        step('0, 0, 8'h00, 0);
        #3 check("R4 reassert wins", 64'(bus_rdata), 64'h8);
        step('0, 1, 8'h00, 32'hFFFF_FFFF);
        step('0, 1, 8'h04, 32'hFFFF_FFFF);
        step('0, 0, 8'h18, 0);
        step('0, 0, 8'h18, 0);
        #3 check("R7 request drops", 64'(irq_req), 64'd0);
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] addrs [10];
            logic [63:0] s;
            addrs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h3C, 8'h0C};
            s = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            if (n % 7 == 0) s = '0;
            step(s, ($urandom % 3) == 0, addrs[$urandom % 10], $urandom);
        end
        step('0, 0, 8'h00, 0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule